// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-visible register bank of a single-channel memory-copy engine that walks a ring of descriptors. Software reaches it through a plain word-indexed write/read port with two halfword write enables, so the lower and upper 16 bits of any word can be written on their own. It holds the ring configuration (base address, next-descriptor pointer, entry count, last address and size, prefetch limit), a control word, a transfer-size code, and the interrupt enable and status bits. All of these feed the descriptor engine, which sits outside this block.

The engine side is a small handshake. The bank issues a one-cycle start strobe. It also holds pause and abort requests as levels until the engine answers with the matching done pulse. The engine reports invalid-descriptor, immediate-pause, error and descriptor-done events as single-cycle pulses, and it reports a live busy level. Completion flags in the control word are sticky and write-one-to-clear. The interrupt status bits behave the same way. One interrupt line is the OR of the pending status bits that are enabled.

Register words (word index on `reg_addr`): 0 ring base low, 1 ring base high, 2 next descriptor address, 3 ring entry count, 4 last address, 5 last size, 6 prefetch limit, 7 control, 8 interrupt. Any other index reads zero.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads zero, except the control word, which reads 0x0000_1700 (done flags at bits 8, 9, 10 and 12 set). `eng_start`, `eng_pause_req`, `eng_abort_req` and `irq` are low.
- R2: Configuration words 0 to 6 read back what was written, truncated to their field width: the high base is HI_W bits, the count CNT_W, the last size SIZE_W, the prefetch PREF_W, and the rest are 32 bits. `reg_hsel[0]` writes bits 15:0 only and `reg_hsel[1]` writes bits 31:16 only. The values appear on the matching `cfg_*` outputs, and writing zeros returns those outputs to zero.
- R3: Writing 1 to control bit 3 drives `eng_start` high for exactly the one cycle after the write, and bit 3 always reads 0. The write is ignored while an abort request is pending.
- R4: Writing 1 to control bit 0 raises `eng_pause_req`, and bit 0 reads it back. Writing 0 does not drop the request. An `eng_pause_done` pulse clears it and sets the pause-done flag at bit 9.
- R5: Writing 1 to control bit 1 raises `eng_abort_req`, held the same way until an `eng_abort_done` pulse. That pulse clears it and sets the abort-done flag at bit 10.
- R6: Control bits 8 (invalid descriptor), 9 (pause done), 10 (abort done) and 12 (immediate pause done) are set by `eng_invalid_desc`, `eng_pause_done`, `eng_abort_done` and `eng_imm_pause_done`. Writing 1 clears a flag and writing 0 leaves it unchanged. When a clear and an event land in the same cycle, the flag stays set.
- R7: Control bit 2 (write-back enable) and bit 4 (ring stop mode) are plain read/write bits. Bits 6:5 hold the descriptor mode: 0 block, 1 local, 2 ring in memory. A written value of 3 is ignored and the field keeps its previous value.
- R8: Control bits 18:16 hold the transfer-size code, written through the upper halfword: 0 = 64 B, 1 = 128 B, 2 = 256 B, 3 = 512 B, 4 = 1 KB, 5 = 2 KB, 7 = 4 B. Code 6 is ignored.
- R9: Control bit 30 reads the live `eng_busy` level.
- R10: Interrupt word bits 21:16 are status flags: 16 error, 17 invalid descriptor, 18 descriptor done, 19 abort done, 20 pause done, 21 immediate pause done. Each is set by its engine pulse and cleared by writing 1 through the upper halfword.
- R11: Interrupt word bits 5:0 are enables, matching status bits 0 to 5. Bit 2 is not stored and reads 0. `irq` is high whenever a status bit is set and enabled, and descriptor done always counts as enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word index for both read and write |
| reg_hsel | input | 2 | Halfword write enables (bit 0 low half, bit 1 high half) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| eng_busy | input | 1 | Engine transfer in progress |
| eng_pause_done | input | 1 | Graceful pause completed (pulse) |
| eng_imm_pause_done | input | 1 | Immediate pause completed (pulse) |
| eng_abort_done | input | 1 | Abort completed (pulse) |
| eng_invalid_desc | input | 1 | Invalid descriptor seen (pulse) |
| eng_error | input | 1 | Transfer error (pulse) |
| eng_desc_done | input | 1 | Descriptor completed (pulse) |
| eng_start | output | 1 | One-cycle start strobe |
| eng_pause_req | output | 1 | Graceful pause request level |
| eng_abort_req | output | 1 | Abort request level |
| cfg_ring_base | output | HI_W+32 | Ring base address |
| cfg_next_addr | output | 32 | Next descriptor address |
| cfg_ring_count | output | CNT_W | Ring entry count |
| cfg_last_addr | output | 32 | Last address |
| cfg_last_size | output | SIZE_W | Last size |
| cfg_pref_limit | output | PREF_W | Descriptor prefetch limit |
| cfg_wback_en | output | 1 | Descriptor write-back enable |
| cfg_ring_stop | output | 1 | Ring stop mode |
| cfg_desc_mode | output | 2 | Descriptor mode |
| cfg_xfer_size | output | 3 | Maximum transfer-size code |
| irq | output | 1 | Interrupt line |

## Verification
The hardest case to reach is a write-one-to-clear that lands in the same clock edge as the engine event setting the same flag. The bench reaches it by raising the pause-done pulse and the clearing write on one falling edge, then reading the flag back. The bench also checks that a pause or abort request survives a later write of 0. It holds an abort request open and issues a start write, then checks that no strobe comes out. Reserved mode and size codes are written over known legal values, so the bench can see that the register kept its old value.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
   localparam int WORD_W  = 32;
   localparam int HALF_W  = 16;
   localparam int NUM_CFG = 7;
   localparam int IX_CTRL = 7;
   localparam int IX_IRQ  = 8;

   // control word bit positions (software decodes these)
   localparam int CB_PAUSE   = 0;
   localparam int CB_ABORT   = 1;
   localparam int CB_WBACK   = 2;
   localparam int CB_START   = 3;
   localparam int CB_STOPM   = 4;
   localparam int CB_MODE_LO = 5;
   localparam int CB_INVD    = 8;
   localparam int CB_PDONE   = 9;
   localparam int CB_ADONE   = 10;
   localparam int CB_IDONE   = 12;
   localparam int CB_XFER_LO = 16;
   localparam int CB_BUSY    = 30;

   typedef enum logic [1:0] {
      DM_BLOCK = 2'd0,
      DM_LOCAL = 2'd1,
      DM_RING  = 2'd2,
      DM_RSVD  = 2'd3
   } dmode_e;

   localparam logic [2:0] XFER_RSVD = 3'd6;

   // interrupt event bit positions
   localparam int EV_ERR   = 0;
   localparam int EV_INVD  = 1;
   localparam int EV_DDONE = 2;
   localparam int EV_ADONE = 3;
   localparam int EV_PDONE = 4;
   localparam int EV_IDONE = 5;
   localparam int NUM_EV   = 6;
endpackage

// File: rtl/dmareg_field.sv
module dmareg_field #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_lo,
   input  logic         we_hi,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   import dmareg_pkg::*;

   if (W < 1 || W > WORD_W) begin : g_bad_width
      $error("dmareg_field: W must lie in 1..32");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (b < HALF_W) begin : g_lo
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q[b] <= 1'b0;
            else if (we_lo) q[b] <= d[b];
         end
      end else begin : g_hi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q[b] <= 1'b0;
            else if (we_hi) q[b] <= d[b];
         end
      end
   end

   if (W <= HALF_W) begin : g_no_hi
      logic unused_we_hi;
      assign unused_we_hi = we_hi;
   end
endmodule

// File: rtl/dmareg_cfg.sv
module dmareg_cfg #(
   parameter int IDX_W  = 4,
   parameter int HI_W   = 16,
   parameter int CNT_W  = 12,
   parameter int SIZE_W = 27,
   parameter int PREF_W = 8,
   parameter int TOT_W  = 159
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [1:0]       hsel,
   input  logic [31:0]      wdata,
   output logic [31:0]      rd_data,
   output logic [TOT_W-1:0] cfg_flat
);
   import dmareg_pkg::*;

   function automatic int fw(input int i);
      case (i)
         1:       return HI_W;
         3:       return CNT_W;
         5:       return SIZE_W;
         6:       return PREF_W;
         default: return WORD_W;
      endcase
   endfunction

   function automatic int foff(input int i);
      int s = 0;
      for (int k = 0; k < i; k++) s += fw(k);
      return s;
   endfunction

   localparam int SUM_W = foff(NUM_CFG);

   if (SUM_W != TOT_W) begin : g_bad_total
      $error("dmareg_cfg: TOT_W does not match the field widths");
   end

   logic [31:0] ext [NUM_CFG];

   for (genvar g = 0; g < NUM_CFG; g++) begin : g_fld
      localparam int FW = fw(g);
      localparam int FO = foff(g);
      logic          sel;
      logic [FW-1:0] q;

      assign sel = we && (idx == IDX_W'(g));

      dmareg_field #(.W(FW)) u_fld (
         .clk   (clk),
         .rst_n (rst_n),
         .we_lo (sel && hsel[0]),
         .we_hi (sel && hsel[1]),
         .d     (wdata[FW-1:0]),
         .q     (q)
      );

      assign cfg_flat[FO +: FW] = q;
      assign ext[g]             = 32'(q);
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_CFG; k++) begin
         if (idx == IDX_W'(k)) rd_data = ext[k];
      end
   end
endmodule

// File: rtl/dmareg_ctrl.sv
module dmareg_ctrl
   import dmareg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [15:0] lo_d,
   input  logic [2:0]  hi_d,
   input  logic        eng_busy,
   input  logic        ev_pause_done,
   input  logic        ev_abort_done,
   input  logic        ev_imm_done,
   input  logic        ev_inv_desc,
   output logic        start_pulse,
   output logic        pause_req,
   output logic        abort_req,
   output logic        wback_en,
   output logic        ring_stop,
   output dmode_e      desc_mode,
   output logic [2:0]  xfer_size,
   output logic [31:0] rd
);
   localparam int NUM_DONE = 4;
   localparam int DONE_POS [NUM_DONE] = '{CB_INVD, CB_PDONE, CB_ADONE, CB_IDONE};

   logic                start_wr;
   logic [NUM_DONE-1:0] done;
   logic [NUM_DONE-1:0] done_ev;

   assign start_wr = wr_lo && lo_d[CB_START] && !abort_req;
   assign done_ev  = {ev_imm_done, ev_abort_done, ev_pause_done, ev_inv_desc};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_pulse <= 1'b0;
      else        start_pulse <= start_wr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          pause_req <= 1'b0;
      else if (ev_pause_done)              pause_req <= 1'b0;
      else if (wr_lo && lo_d[CB_PAUSE])    pause_req <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          abort_req <= 1'b0;
      else if (ev_abort_done)              abort_req <= 1'b0;
      else if (wr_lo && lo_d[CB_ABORT])    abort_req <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wback_en  <= 1'b0;
         ring_stop <= 1'b0;
         desc_mode <= DM_BLOCK;
      end else if (wr_lo) begin
         wback_en  <= lo_d[CB_WBACK];
         ring_stop <= lo_d[CB_STOPM];
         if (dmode_e'(lo_d[CB_MODE_LO +: 2]) != DM_RSVD)
            desc_mode <= dmode_e'(lo_d[CB_MODE_LO +: 2]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          xfer_size <= 3'd0;
      else if (wr_hi && hi_d != XFER_RSVD) xfer_size <= hi_d;
   end

   for (genvar i = 0; i < NUM_DONE; i++) begin : g_done
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) done[i] <= 1'b1;
         else        done[i] <= (done[i] & ~(wr_lo & lo_d[DONE_POS[i]])) | done_ev[i];
      end

      // R6: a pending event is never lost to a simultaneous clear
      assert_done_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
         done_ev[i] |=> done[i]);
   end

   always_comb begin
      rd                      = '0;
      rd[CB_PAUSE]            = pause_req;
      rd[CB_ABORT]            = abort_req;
      rd[CB_WBACK]            = wback_en;
      rd[CB_STOPM]            = ring_stop;
      rd[CB_MODE_LO +: 2]     = desc_mode;
      rd[CB_XFER_LO +: 3]     = xfer_size;
      rd[CB_BUSY]             = eng_busy;
      for (int k = 0; k < NUM_DONE; k++) rd[DONE_POS[k]] = done[k];
   end

   logic unused_lo;
   assign unused_lo = ^{lo_d[7], lo_d[11], lo_d[15:13]};

   assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> $past(start_wr));

   assert_start_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_req && wr_lo && lo_d[CB_START]) |=> !start_pulse);

   assert_pause_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_req && !ev_pause_done) |=> pause_req);

   assert_pause_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_pause_done |=> (!pause_req && done[1]));

   assert_abort_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_req && !ev_abort_done) |=> abort_req);

   assert_abort_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_abort_done |=> (!abort_req && done[2]));

   assert_mode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      desc_mode != DM_RSVD);

   assert_xfer_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_size != XFER_RSVD);
endmodule

// File: rtl/dmareg_irq.sv
module dmareg_irq
   import dmareg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [NUM_EV-1:0] en_d,
   input  logic [NUM_EV-1:0] clr_d,
   input  logic [NUM_EV-1:0] ev,
   output logic              irq,
   output logic [31:0]       rd
);
   localparam logic [NUM_EV-1:0] EN_IMPL  = 6'b111011;
   localparam logic [NUM_EV-1:0] EN_FORCE = 6'b000100;

   logic [NUM_EV-1:0] en;
   logic [NUM_EV-1:0] status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en <= '0;
      else if (wr_lo) en <= en_d & EN_IMPL;
   end

   for (genvar i = 0; i < NUM_EV; i++) begin : g_stat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) status[i] <= 1'b0;
         else        status[i] <= (status[i] & ~(wr_hi & clr_d[i])) | ev[i];
      end

      assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (status[i] && !(wr_hi && clr_d[i])) |=> status[i]);
   end

   assign irq = |(status & (en | EN_FORCE));
   assign rd  = {10'd0, status, 10'd0, en};

   assert_desc_done_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ev[EV_DDONE] |=> irq);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
   parameter int ADDR_W = 4,
   parameter int HI_W   = 16,
   parameter int CNT_W  = 12,
   parameter int SIZE_W = 27,
   parameter int PREF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [1:0]        reg_hsel,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              eng_busy,
   input  logic              eng_pause_done,
   input  logic              eng_imm_pause_done,
   input  logic              eng_abort_done,
   input  logic              eng_invalid_desc,
   input  logic              eng_error,
   input  logic              eng_desc_done,
   output logic              eng_start,
   output logic              eng_pause_req,
   output logic              eng_abort_req,
   output logic [HI_W+31:0]  cfg_ring_base,
   output logic [31:0]       cfg_next_addr,
   output logic [CNT_W-1:0]  cfg_ring_count,
   output logic [31:0]       cfg_last_addr,
   output logic [SIZE_W-1:0] cfg_last_size,
   output logic [PREF_W-1:0] cfg_pref_limit,
   output logic              cfg_wback_en,
   output logic              cfg_ring_stop,
   output logic [1:0]        cfg_desc_mode,
   output logic [2:0]        cfg_xfer_size,
   output logic              irq
);
   import dmareg_pkg::*;

   localparam int O_HI   = WORD_W;
   localparam int O_NEXT = O_HI + HI_W;
   localparam int O_CNT  = O_NEXT + WORD_W;
   localparam int O_LAST = O_CNT + CNT_W;
   localparam int O_SIZE = O_LAST + WORD_W;
   localparam int O_PREF = O_SIZE + SIZE_W;
   localparam int TOT_W  = O_PREF + PREF_W;

   if ((1 << ADDR_W) <= IX_IRQ) begin : g_bad_addr
      $error("dma_chan_regs: ADDR_W too small for the register map");
   end

   logic [TOT_W-1:0] cfg_flat;
   logic [31:0]      cfg_rd, ctrl_rd, irq_rd;
   logic             hit_ctrl, hit_irq;
   dmode_e           mode_q;
   logic [NUM_EV-1:0] ev;

   assign hit_ctrl = (reg_addr == ADDR_W'(IX_CTRL));
   assign hit_irq  = (reg_addr == ADDR_W'(IX_IRQ));

   dmareg_cfg #(
      .IDX_W (ADDR_W), .HI_W (HI_W), .CNT_W (CNT_W),
      .SIZE_W(SIZE_W), .PREF_W(PREF_W), .TOT_W (TOT_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .idx      (reg_addr),
      .hsel     (reg_hsel),
      .wdata    (reg_wdata),
      .rd_data  (cfg_rd),
      .cfg_flat (cfg_flat)
   );

   dmareg_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_lo         (reg_we && hit_ctrl && reg_hsel[0]),
      .wr_hi         (reg_we && hit_ctrl && reg_hsel[1]),
      .lo_d          (reg_wdata[15:0]),
      .hi_d          (reg_wdata[CB_XFER_LO +: 3]),
      .eng_busy      (eng_busy),
      .ev_pause_done (eng_pause_done),
      .ev_abort_done (eng_abort_done),
      .ev_imm_done   (eng_imm_pause_done),
      .ev_inv_desc   (eng_invalid_desc),
      .start_pulse   (eng_start),
      .pause_req     (eng_pause_req),
      .abort_req     (eng_abort_req),
      .wback_en      (cfg_wback_en),
      .ring_stop     (cfg_ring_stop),
      .desc_mode     (mode_q),
      .xfer_size     (cfg_xfer_size),
      .rd            (ctrl_rd)
   );

   always_comb begin
      ev            = '0;
      ev[EV_ERR]    = eng_error;
      ev[EV_INVD]   = eng_invalid_desc;
      ev[EV_DDONE]  = eng_desc_done;
      ev[EV_ADONE]  = eng_abort_done;
      ev[EV_PDONE]  = eng_pause_done;
      ev[EV_IDONE]  = eng_imm_pause_done;
   end

   dmareg_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (reg_we && hit_irq && reg_hsel[0]),
      .wr_hi (reg_we && hit_irq && reg_hsel[1]),
      .en_d  (reg_wdata[NUM_EV-1:0]),
      .clr_d (reg_wdata[HALF_W +: NUM_EV]),
      .ev    (ev),
      .irq   (irq),
      .rd    (irq_rd)
   );

   assign cfg_desc_mode  = mode_q;
   assign cfg_ring_base  = {cfg_flat[O_HI +: HI_W], cfg_flat[0 +: WORD_W]};
   assign cfg_next_addr  = cfg_flat[O_NEXT +: WORD_W];
   assign cfg_ring_count = cfg_flat[O_CNT +: CNT_W];
   assign cfg_last_addr  = cfg_flat[O_LAST +: WORD_W];
   assign cfg_last_size  = cfg_flat[O_SIZE +: SIZE_W];
   assign cfg_pref_limit = cfg_flat[O_PREF +: PREF_W];

   always_comb begin
      if (hit_ctrl)     reg_rdata = ctrl_rd;
      else if (hit_irq) reg_rdata = irq_rd;
      else              reg_rdata = cfg_rd;
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!eng_start && !eng_pause_req && !eng_abort_req));
endmodule

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 4;
   localparam int WATCHDOG   = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [1:0]  reg_hsel = 2'b00;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        eng_busy = 1'b0, eng_pause_done = 1'b0, eng_imm_pause_done = 1'b0;
   logic        eng_abort_done = 1'b0, eng_invalid_desc = 1'b0, eng_error = 1'b0;
   logic        eng_desc_done = 1'b0;
   logic        eng_start, eng_pause_req, eng_abort_req, irq;
   logic [47:0] cfg_ring_base;
   logic [31:0] cfg_next_addr, cfg_last_addr;
   logic [11:0] cfg_ring_count;
   logic [26:0] cfg_last_size;
   logic [7:0]  cfg_pref_limit;
   logic        cfg_wback_en, cfg_ring_stop;
   logic [1:0]  cfg_desc_mode;
   logic [2:0]  cfg_xfer_size;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_chan_regs i_dma_chan_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_hsel(reg_hsel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_busy(eng_busy), .eng_pause_done(eng_pause_done),
      .eng_imm_pause_done(eng_imm_pause_done), .eng_abort_done(eng_abort_done),
      .eng_invalid_desc(eng_invalid_desc), .eng_error(eng_error),
      .eng_desc_done(eng_desc_done), .eng_start(eng_start),
      .eng_pause_req(eng_pause_req), .eng_abort_req(eng_abort_req),
      .cfg_ring_base(cfg_ring_base), .cfg_next_addr(cfg_next_addr),
      .cfg_ring_count(cfg_ring_count), .cfg_last_addr(cfg_last_addr),
      .cfg_last_size(cfg_last_size), .cfg_pref_limit(cfg_pref_limit),
      .cfg_wback_en(cfg_wback_en), .cfg_ring_stop(cfg_ring_stop),
      .cfg_desc_mode(cfg_desc_mode), .cfg_xfer_size(cfg_xfer_size), .irq(irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [1:0] hs, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = ADDR_W'(idx); reg_hsel = hs; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0; reg_hsel = 2'b00;
   endtask

   task automatic rd(input int idx, output logic [31:0] d);
      reg_addr = ADDR_W'(idx);
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: eng_pause_done = 1'b1;
         1: eng_abort_done = 1'b1;
         2: eng_imm_pause_done = 1'b1;
         3: eng_invalid_desc = 1'b1;
         4: eng_error = 1'b1;
         default: eng_desc_done = 1'b1;
      endcase
      @(negedge clk);
      eng_pause_done = 1'b0; eng_abort_done = 1'b0; eng_imm_pause_done = 1'b0;
      eng_invalid_desc = 1'b0; eng_error = 1'b0; eng_desc_done = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(7, v); chk("R1 control word", v, 32'h0000_1700);
      rd(0, v); chk("R1 ring base low", v, 0);
      rd(8, v); chk("R1 interrupt word", v, 0);
      chk("R1 strobes and irq", {eng_start, eng_pause_req, eng_abort_req, irq}, 0);
   endtask

   task automatic t_config;
      logic [31:0] v;
      wr(0, 2'b11, 32'hDEAD_BEEF); rd(0, v); chk("R2 base low full", v, 32'hDEAD_BEEF);
      wr(1, 2'b11, 32'h1234_5678); rd(1, v); chk("R2 base high truncated", v, 32'h5678);
      wr(3, 2'b11, 32'hFFFF_FFFF); rd(3, v); chk("R2 count truncated", v, 32'hFFF);
      wr(5, 2'b11, 32'hFFFF_FFFF); rd(5, v); chk("R2 size truncated", v, 32'h07FF_FFFF);
      wr(6, 2'b11, 32'hFFFF_FFFF); rd(6, v); chk("R2 prefetch truncated", v, 32'hFF);
      wr(0, 2'b01, 32'h0000_1111); rd(0, v); chk("R2 low halfword", v, 32'hDEAD_1111);
      wr(0, 2'b10, 32'hAAAA_0000); rd(0, v); chk("R2 high halfword", v, 32'hAAAA_1111);
      chk("R2 base output", cfg_ring_base, 48'h5678_AAAA_1111);
      wr(2, 2'b11, 32'h0000_4000); chk("R2 next output", cfg_next_addr, 32'h4000);
      for (int k = 0; k < 7; k++) wr(k, 2'b11, 32'h0);
      chk("R2 zeroed outputs", {cfg_ring_base, cfg_next_addr, cfg_ring_count, cfg_pref_limit}, 0);
   endtask

   task automatic t_mode;
      logic [31:0] v;
      wr(7, 2'b01, 32'h0000_0054); rd(7, v); chk("R7 mode ring with flags", v, 32'h0000_1754);
      chk("R7 outputs", {cfg_desc_mode, cfg_wback_en, cfg_ring_stop}, {2'd2, 1'b1, 1'b1});
      wr(7, 2'b01, 32'h0000_0060); rd(7, v); chk("R7 reserved mode ignored", v, 32'h0000_1740);
      chk("R7 mode output kept", cfg_desc_mode, 2'd2);
   endtask

   task automatic t_xfer;
      logic [31:0] v;
      wr(7, 2'b10, 32'h0005_0000); chk("R8 size 2KB", cfg_xfer_size, 3'd5);
      wr(7, 2'b10, 32'h0006_0000); chk("R8 code 6 ignored", cfg_xfer_size, 3'd5);
      wr(7, 2'b10, 32'h0007_0000); rd(7, v); chk("R8 size 4B readback", v, 32'h0007_1740);
   endtask

   task automatic t_busy;
      logic [31:0] v;
      eng_busy = 1'b1; rd(7, v); chk("R9 busy high", v[30], 1'b1);
      eng_busy = 1'b0; rd(7, v); chk("R9 busy low", v[30], 1'b0);
   endtask

   task automatic t_start;
      logic [31:0] v;
      wr(7, 2'b01, 32'h0000_0008);
      chk("R3 strobe high", eng_start, 1'b1);
      rd(7, v); chk("R3 start reads zero", v, 32'h0007_1700);
      @(negedge clk); chk("R3 strobe one cycle", eng_start, 1'b0);
   endtask

   task automatic t_pause;
      logic [31:0] v;
      wr(7, 2'b01, 32'h0000_0201);
      chk("R4 request raised", eng_pause_req, 1'b1);
      rd(7, v); chk("R4 flag cleared request visible", v, 32'h0007_1501);
      wr(7, 2'b01, 32'h0000_0000);
      rd(7, v); chk("R4 zero write keeps request and flags", v, 32'h0007_1501);
      pulse(0);
      chk("R4 request dropped", eng_pause_req, 1'b0);
      rd(7, v); chk("R4 done flag set", v, 32'h0007_1700);
   endtask

   task automatic t_abort;
      logic [31:0] v;
      wr(7, 2'b01, 32'h0000_0402);
      chk("R5 request raised", eng_abort_req, 1'b1);
      rd(7, v); chk("R5 readback", v, 32'h0007_1302);
      wr(7, 2'b01, 32'h0000_0008);
      chk("R3 start blocked during abort", eng_start, 1'b0);
      @(negedge clk); chk("R3 start still blocked", eng_start, 1'b0);
      chk("R5 request held", eng_abort_req, 1'b1);
      pulse(1);
      chk("R5 request dropped", eng_abort_req, 1'b0);
      rd(7, v); chk("R5 done flag set", v, 32'h0007_1700);
      wr(7, 2'b01, 32'h0000_0008);
      chk("R3 start after abort", eng_start, 1'b1);
   endtask

   task automatic t_done;
      logic [31:0] v;
      wr(7, 2'b01, 32'h0000_1100); rd(7, v); chk("R6 selective clear", v, 32'h0007_0600);
      pulse(3); rd(7, v); chk("R6 invalid descriptor flag", v, 32'h0007_0700);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'd7; reg_hsel = 2'b01; reg_wdata = 32'h0000_0200;
      eng_pause_done = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; reg_hsel = 2'b00; eng_pause_done = 1'b0;
      rd(7, v); chk("R6 event beats clear", v, 32'h0007_0700);
      pulse(2); rd(7, v); chk("R6 immediate pause flag", v, 32'h0007_1700);
   endtask

   task automatic t_irq;
      logic [31:0] v;
      rd(8, v); chk("R10 collected status", v, 32'h003A_0000);
      chk("R11 nothing enabled", irq, 1'b0);
      wr(8, 2'b01, 32'h0000_003F); rd(8, v); chk("R11 enable bit 2 absent", v, 32'h003A_003B);
      chk("R11 enabled irq", irq, 1'b1);
      wr(8, 2'b10, 32'h003A_0000); rd(8, v); chk("R10 clear all", v, 32'h0000_003B);
      chk("R11 irq drops", irq, 1'b0);
      wr(8, 2'b01, 32'h0);
      pulse(5); chk("R11 descriptor done forced", irq, 1'b1);
      rd(8, v); chk("R10 descriptor done status", v, 32'h0004_0000);
      wr(8, 2'b01, 32'h0000_0001); pulse(4);
      rd(8, v); chk("R10 error status", v, 32'h0005_0001);
      wr(8, 2'b10, 32'h0004_0000); rd(8, v); chk("R10 single clear", v, 32'h0001_0001);
      chk("R11 error enabled", irq, 1'b1);
      wr(8, 2'b01, 32'h0); chk("R11 error masked", irq, 1'b0);
      rd(8, v); chk("R10 masked bit stays pending", v, 32'h0001_0000);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_config();
      t_mode();
      t_xfer();
      t_busy();
      t_start();
      t_pause();
      t_abort();
      t_done();
      t_irq();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule